// File: doc/BRIEF.md
# Interprocessor Interrupt Command Register

This block holds the command register pair that a processor programs to send a message to other processors. Software sees two 32-bit words. The high word holds only the target identifier. Writing the high word stores that identifier and does nothing else. Writing the low word supplies the vector, the delivery mode, the level and the trigger setting, and a two-bit shorthand. That write launches the message.

Once launched, the message is offered on a valid/ready handshake toward a bus model. The fields are frozen until the handshake completes. While the message waits, a busy bit in the low word reads as one, and software polls it until it clears. The shorthand can replace the stored identifier. It can target the sending processor's own identifier, or the all-ones broadcast identifier. A low-word write made while a message is pending is dropped, and an error flag is raised.

Top module: `ipi_cmd_reg`

## Requirements
- R1: After reset, msg_valid and send_err are 0, and both words read back as 0x00000000.
- R2: A high-word write stores bits [ID_LSB+ID_W-1:ID_LSB] (bits 31:24 by default). The high word reads back that field with every other bit 0. A high-word write never raises msg_valid.
- R3: A low-word write while idle raises msg_valid on the next cycle. The message fields are taken from the write data: msg_vector from bits 7:0, msg_mode from bits 10:8 (000 fixed, 100 NMI, 101 INIT, 110 startup), msg_level from bit 14 (1 assert, 0 deassert) and msg_trigger from bit 15 (1 level, 0 edge). For a startup message, the vector is the start page number, passed through unchanged.
- R4: The shorthand in low-word bits 19:18 sets msg_dest. With 00, msg_dest is the stored high-word identifier. With 01, it is SELF_ID. With 10 (all including self) and 11 (all excluding self), it is all ones. msg_shorthand repeats the two bits.
- R5: Low-word bit 12 reads 1 exactly while msg_valid is 1. Both clear on the cycle after the handshake completes with msg_valid and msg_ready both 1.
- R6: A low-word write made while a message is pending leaves every message output unchanged and sets send_err. This holds even in the cycle in which the pending message is accepted.
- R7: send_err stays set until the next low-word write that is accepted, which clears it.
- R8: The low word reads back the last accepted command in the same bit positions. Bits 17:16 (remote read status) read as 00 (invalid). All other bits not listed in R3 to R5 read 0.
- R9: A high-word write while a message is pending updates the high-word readback but not msg_dest of the pending message.
- R10: While msg_valid is 1 and msg_ready is 0, msg_valid and all message fields hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel_hi | input | 1 | Write target: 1 high word, 0 low word |
| wr_data | input | 32 | Write data |
| rd_sel_hi | input | 1 | Read select: 1 high word, 0 low word |
| rd_data | output | 32 | Combinational readback |
| msg_valid | output | 1 | Message offered to the bus model |
| msg_ready | input | 1 | Bus model accepts the message |
| msg_vector | output | 8 | Vector or start page |
| msg_mode | output | 3 | Delivery mode |
| msg_level | output | 1 | Level: assert (1) or deassert (0) |
| msg_trigger | output | 1 | Trigger: level (1) or edge (0) |
| msg_shorthand | output | 2 | Destination shorthand |
| msg_dest | output | ID_W | Resolved destination identifier |
| send_err | output | 1 | A low-word write was dropped while busy |

## Verification
Acceptance of a pending message and a new low-word write can happen on the same clock edge. The bench provokes this by raising msg_ready in the same cycle as a low-word write. It then checks that the message clears, that no new message appears, and that send_err is set. A second collision, a high-word write during a pending message, is judged by reading back the high word and checking that msg_dest is unchanged.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
   localparam int REG_W = 32;

   localparam int VEC_LSB  = 0;
   localparam int MODE_LSB = 8;
   localparam int BUSY_BIT = 12;
   localparam int LVL_BIT  = 14;
   localparam int TRIG_BIT = 15;
   localparam int SH_LSB   = 18;

   typedef enum logic [2:0] {
      DM_FIXED = 3'b000,
      DM_NMI   = 3'b100,
      DM_INIT  = 3'b101,
      DM_START = 3'b110
   } dmode_e;

   typedef enum logic [1:0] {
      SH_FIELD   = 2'b00,
      SH_SELF    = 2'b01,
      SH_ALL_INC = 2'b10,
      SH_ALL_EXC = 2'b11
   } shorthand_e;

   typedef struct packed {
      logic [1:0] shorthand;
      logic       trigger;
      logic       level;
      logic [2:0] mode;
      logic [7:0] vector;
   } ipi_cmd_t;
endpackage

// File: rtl/ipi_field_dec.sv
module ipi_field_dec
   import ipi_pkg::*;
(
   input  logic [REG_W-1:0] word,
   output ipi_cmd_t         cmd
);
   always_comb begin
      cmd.vector    = word[VEC_LSB +: 8];
      cmd.mode      = word[MODE_LSB +: 3];
      cmd.level     = word[LVL_BIT];
      cmd.trigger   = word[TRIG_BIT];
      cmd.shorthand = word[SH_LSB +: 2];
   end

   logic unused_bits;
   assign unused_bits = ^{word[REG_W-1:SH_LSB+2], word[17:16], word[13:11]};
endmodule

// File: rtl/ipi_dest_sel.sv
module ipi_dest_sel
   import ipi_pkg::*;
#(
   parameter int          ID_W    = 8,
   parameter int unsigned SELF_ID = 5
) (
   input  logic [1:0]      shorthand,
   input  logic [ID_W-1:0] field_id,
   output logic [ID_W-1:0] dest_id
);
   localparam logic [ID_W-1:0] SELF_V = ID_W'(SELF_ID);

   always_comb begin
      unique case (shorthand_e'(shorthand))
         SH_FIELD:   dest_id = field_id;
         SH_SELF:    dest_id = SELF_V;
         default:    dest_id = '1;
      endcase
   end
endmodule

// File: rtl/ipi_launch_ctl.sv
module ipi_launch_ctl
   import ipi_pkg::*;
#(
   parameter int ID_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            lo_wr,
   input  ipi_cmd_t        cmd_in,
   input  logic [ID_W-1:0] dest_in,
   input  logic            ready,
   output logic            busy,
   output logic            err,
   output ipi_cmd_t        cmd_q,
   output logic [ID_W-1:0] dest_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         err    <= 1'b0;
         cmd_q  <= '0;
         dest_q <= '0;
      end else if (lo_wr && !busy) begin
         busy   <= 1'b1;
         err    <= 1'b0;
         cmd_q  <= cmd_in;
         dest_q <= dest_in;
      end else begin
         if (busy && ready) busy <= 1'b0;
         if (lo_wr && busy) err  <= 1'b1;
      end
   end
endmodule

// File: rtl/ipi_cmd_reg.sv
module ipi_cmd_reg
   import ipi_pkg::*;
#(
   parameter int          ID_W    = 8,
   parameter int          ID_LSB  = 24,
   parameter int unsigned SELF_ID = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic            wr_sel_hi,
   input  logic [31:0]     wr_data,
   input  logic            rd_sel_hi,
   output logic [31:0]     rd_data,
   output logic            msg_valid,
   input  logic            msg_ready,
   output logic [7:0]      msg_vector,
   output logic [2:0]      msg_mode,
   output logic            msg_level,
   output logic            msg_trigger,
   output logic [1:0]      msg_shorthand,
   output logic [ID_W-1:0] msg_dest,
   output logic            send_err
);
   localparam int ID_MSB = ID_LSB + ID_W - 1;

   generate
      if (ID_W < 1 || ID_W > 8) begin : g_bad_idw
         $error("ipi_cmd_reg: ID_W must be 1..8");
      end
      if (ID_LSB < 0 || ID_MSB >= REG_W) begin : g_bad_lsb
         $error("ipi_cmd_reg: identifier field outside the word");
      end
      if (SELF_ID >= (1 << ID_W)) begin : g_bad_self
         $error("ipi_cmd_reg: SELF_ID does not fit ID_W");
      end
   endgenerate

   logic [ID_W-1:0] hi_id;
   logic            lo_wr;
   ipi_cmd_t        cmd_dec, cmd_q;
   logic [ID_W-1:0] dest_res;
   logic            busy;
   logic [31:0]     hi_word, lo_word;

   assign lo_wr = wr_en && !wr_sel_hi;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                hi_id <= '0;
      else if (wr_en && wr_sel_hi) hi_id <= wr_data[ID_LSB +: ID_W];
   end

   ipi_field_dec dec_i (
      .word (wr_data),
      .cmd  (cmd_dec)
   );

   ipi_dest_sel #(.ID_W(ID_W), .SELF_ID(SELF_ID)) dsel_i (
      .shorthand (cmd_dec.shorthand),
      .field_id  (hi_id),
      .dest_id   (dest_res)
   );

   ipi_launch_ctl #(.ID_W(ID_W)) ctl_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .lo_wr   (lo_wr),
      .cmd_in  (cmd_dec),
      .dest_in (dest_res),
      .ready   (msg_ready),
      .busy    (busy),
      .err     (send_err),
      .cmd_q   (cmd_q),
      .dest_q  (msg_dest)
   );

   generate
      for (genvar b = 0; b < REG_W; b++) begin : g_hi_rd
         if (b >= ID_LSB && b <= ID_MSB) begin : g_id
            assign hi_word[b] = hi_id[b-ID_LSB];
         end else begin : g_zero
            assign hi_word[b] = 1'b0;
         end
      end
   endgenerate

   always_comb begin
      lo_word                     = '0;
      lo_word[VEC_LSB +: 8]       = cmd_q.vector;
      lo_word[MODE_LSB +: 3]      = cmd_q.mode;
      lo_word[BUSY_BIT]           = busy;
      lo_word[LVL_BIT]            = cmd_q.level;
      lo_word[TRIG_BIT]           = cmd_q.trigger;
      lo_word[SH_LSB +: 2]        = cmd_q.shorthand;
   end

   assign rd_data       = rd_sel_hi ? hi_word : lo_word;
   assign msg_valid     = busy;
   assign msg_vector    = cmd_q.vector;
   assign msg_mode      = cmd_q.mode;
   assign msg_level     = cmd_q.level;
   assign msg_trigger   = cmd_q.trigger;
   assign msg_shorthand = cmd_q.shorthand;
endmodule

// File: rtl/ipi_cmd_reg_chk.sv
module ipi_cmd_reg_chk #(
   parameter int          ID_W    = 8,
   parameter int          ID_LSB  = 24,
   parameter int unsigned SELF_ID = 5
) (
   input logic            clk,
   input logic            rst_n,
   input logic            wr_en,
   input logic            wr_sel_hi,
   input logic [31:0]     wr_data,
   input logic            rd_sel_hi,
   input logic [31:0]     rd_data,
   input logic            msg_valid,
   input logic            msg_ready,
   input logic [7:0]      msg_vector,
   input logic [2:0]      msg_mode,
   input logic            msg_level,
   input logic            msg_trigger,
   input logic [1:0]      msg_shorthand,
   input logic [ID_W-1:0] msg_dest,
   input logic            send_err
);
   p_launch_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_sel_hi && !msg_valid) |=> msg_valid);

   p_hi_no_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!msg_valid && !(wr_en && !wr_sel_hi)) |=> !msg_valid);

   p_self_dest_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && msg_shorthand == 2'b01) |-> msg_dest == ID_W'(SELF_ID));

   p_bcast_dest_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && msg_shorthand[1]) |-> msg_dest == '1);

   p_busy_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_sel_hi |-> rd_data[12] == msg_valid);

   p_accept_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && msg_ready) |=> !msg_valid);

   p_drop_sets_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && wr_en && !wr_sel_hi) |=> send_err);

   p_accept_clears_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!msg_valid && wr_en && !wr_sel_hi) |=> !send_err);

   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_vector) &&
         $stable(msg_mode) && $stable(msg_dest) && $stable(msg_shorthand)));
endmodule

bind ipi_cmd_reg ipi_cmd_reg_chk #(.ID_W(ID_W), .ID_LSB(ID_LSB), .SELF_ID(SELF_ID)) chk_i (.*);

// File: tb/ipi_cmd_reg_tb_top.sv
module ipi_cmd_reg_tb_top;
   localparam int SELF = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0, wr_sel_hi = 1'b0, rd_sel_hi = 1'b0, msg_ready = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        msg_valid, msg_level, msg_trigger, send_err;
   logic [7:0]  msg_vector, msg_dest;
   logic [2:0]  msg_mode;
   logic [1:0]  msg_shorthand;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   ipi_cmd_reg #(.ID_W(8), .ID_LSB(24), .SELF_ID(SELF)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel_hi(wr_sel_hi),
      .wr_data(wr_data), .rd_sel_hi(rd_sel_hi), .rd_data(rd_data),
      .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vector(msg_vector),
      .msg_mode(msg_mode), .msg_level(msg_level), .msg_trigger(msg_trigger),
      .msg_shorthand(msg_shorthand), .msg_dest(msg_dest), .send_err(send_err)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] lo_val(input logic [7:0] v, input logic [2:0] m,
                                         input logic l, input logic t,
                                         input logic [1:0] s, input logic b);
      return (32'(s) << 18) | (32'(t) << 15) | (32'(l) << 14) |
             (32'(b) << 12) | (32'(m) << 8) | 32'(v);
   endfunction

   task automatic wr(input logic hi, input logic [31:0] d, input logic rdy);
      @(negedge clk);
      wr_en = 1'b1; wr_sel_hi = hi; wr_data = d; msg_ready = rdy;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0; msg_ready = 1'b0;
   endtask

   task automatic accept();
      @(negedge clk);
      msg_ready = 1'b1;
      @(posedge clk);
      @(negedge clk);
      msg_ready = 1'b0;
   endtask

   function automatic logic [7:0] exp_dest(input logic [1:0] s, input logic [7:0] fid);
      if (s == 2'b00) return fid;
      if (s == 2'b01) return 8'(SELF);
      return 8'hFF;
   endfunction

   initial begin
      logic [2:0] modes [4];
      modes[0] = 3'b000; modes[1] = 3'b100; modes[2] = 3'b101; modes[3] = 3'b110;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 valid", 32'(msg_valid), 0);
      chk("R1 err", 32'(send_err), 0);
      rd_sel_hi = 1'b0; #1 chk("R1 lo", rd_data, 0);
      rd_sel_hi = 1'b1; #1 chk("R1 hi", rd_data, 0);

      // R2 high-only write
      wr(1'b1, 32'hA5FF_FFFF, 1'b0);
      rd_sel_hi = 1'b1; #1 chk("R2 hi readback", rd_data, 32'hA500_0000);
      chk("R2 no launch", 32'(msg_valid), 0);
      @(negedge clk);
      chk("R2 still idle", 32'(msg_valid), 0);

      // R3/R4/R5/R8/R10 sweep: all shorthands x all modes
      for (int s = 0; s < 4; s++) begin
         for (int mi = 0; mi < 4; mi++) begin
            logic [7:0] v, fid;
            logic l, t;
            logic [31:0] w;
            v   = 8'(s * 61 + mi * 17 + 3);
            fid = 8'(s * 37 + mi * 11 + 1);
            l   = mi[0];
            t   = s[0] ^ mi[1];
            wr(1'b1, {fid, 24'h00FFFF}, 1'b0);
            w = lo_val(v, modes[mi], l, t, 2'(s), 1'b1) | 32'h0003_2800;
            wr(1'b0, w, 1'b0);
            chk("R3 valid", 32'(msg_valid), 1);
            chk("R3 vector", 32'(msg_vector), 32'(v));
            chk("R3 mode", 32'(msg_mode), 32'(modes[mi]));
            chk("R3 level", 32'(msg_level), 32'(l));
            chk("R3 trigger", 32'(msg_trigger), 32'(t));
            chk("R4 shorthand", 32'(msg_shorthand), 32'(s));
            chk("R4 dest", 32'(msg_dest), 32'(exp_dest(2'(s), fid)));
            rd_sel_hi = 1'b0; #1
            chk("R8 lo readback busy", rd_data, lo_val(v, modes[mi], l, t, 2'(s), 1'b1));
            @(negedge clk);
            chk("R10 hold valid", 32'(msg_valid), 1);
            chk("R10 hold vector", 32'(msg_vector), 32'(v));
            accept();
            chk("R5 cleared", 32'(msg_valid), 0);
            rd_sel_hi = 1'b0; #1
            chk("R5 busy bit clear", rd_data, lo_val(v, modes[mi], l, t, 2'(s), 1'b0));
         end
      end

      // R6 write while busy dropped; R9 hi write while busy
      wr(1'b1, 32'h4200_0000, 1'b0);
      wr(1'b0, lo_val(8'h33, 3'b101, 1'b1, 1'b1, 2'b00, 1'b0), 1'b0);
      chk("R6 setup dest", 32'(msg_dest), 32'h42);
      wr(1'b0, lo_val(8'hC4, 3'b110, 1'b0, 1'b0, 2'b01, 1'b0), 1'b0);
      chk("R6 vector kept", 32'(msg_vector), 32'h33);
      chk("R6 mode kept", 32'(msg_mode), 32'h5);
      chk("R6 shorthand kept", 32'(msg_shorthand), 0);
      chk("R6 err set", 32'(send_err), 1);
      wr(1'b1, 32'h9900_0000, 1'b0);
      chk("R9 dest kept", 32'(msg_dest), 32'h42);
      rd_sel_hi = 1'b1; #1 chk("R9 hi readback", rd_data, 32'h9900_0000);
      chk("R7 err held", 32'(send_err), 1);
      accept();

      // R7 accepted write clears error
      wr(1'b0, lo_val(8'h08, 3'b110, 1'b0, 1'b0, 2'b00, 1'b0), 1'b0);
      chk("R7 err cleared", 32'(send_err), 0);
      chk("R7 startup page", 32'(msg_vector), 32'h08);
      chk("R9 new dest used", 32'(msg_dest), 32'h99);

      // R6 collision: write in the same cycle as acceptance
      wr(1'b0, lo_val(8'h77, 3'b000, 1'b1, 1'b0, 2'b10, 1'b0), 1'b1);
      chk("R6 collision no relaunch", 32'(msg_valid), 0);
      chk("R6 collision err", 32'(send_err), 1);
      rd_sel_hi = 1'b0; #1
      chk("R6 collision lo unchanged", rd_data, lo_val(8'h08, 3'b110, 1'b0, 1'b0, 2'b00, 1'b0));

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule